// File: doc/BRIEF.md
# Partitioned SIMD Integer Subtractor

This block subtracts one 128-bit vector from another, lane by lane, and registers the result in a single pipeline stage. A two-bit opcode field picks the lane size (bytes, halfwords, words or doublewords of 64 bits). A wide-mode bit picks whether the operation covers all 128 bits or only the low 64. Each lane result replaces the matching lane of the first operand. A lane that overflows wraps around, and no status of any kind is produced. Signed and unsigned data use the same hardware.

The datapath is a single ripple borrow chain built from sixteen 8-bit slices. Cuts that depend on the lane size split the chain into 16, 8, 4 or 2 independent lanes. In narrow mode the upper half of the first operand passes through to the result unchanged. A valid flag travels alongside the data. The result register loads only when valid-in is high and holds its value otherwise.

Top module: `psub_unit`

## Requirements
- R1: The result presented one cycle after a sampled valid-in is, for every active lane, the first operand's lane minus the second operand's lane.
- R2: The lane size is set by `opc`: 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit, 2'b10 selects 32-bit and 2'b11 selects 64-bit.
- R3: A lane result keeps only its low lane-width bits. No borrow crosses from one lane into the next, at any lane size; for example, all zeros minus all ones gives 1 in every lane.
- R4: With `wide`=1 all 128 bits are processed. With `wide`=0 only bits [63:0] are processed, so 64-bit lanes give one quadword difference in narrow mode and two independent ones in wide mode.
- R5: With `wide`=0, result bits [127:64] equal bits [127:64] of the first operand from the same issue.
- R6: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-high reset clears `out_valid` and sets `result` to zero.
- R7: When `in_valid` is low, `result` keeps its previous value on the next clock.
- R8: Operands in two's complement give the correct signed difference modulo the lane width, using the same hardware as unsigned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and selects are sampled when high |
| opc | input | 2 | Lane-size code: 00=8, 01=16, 10=32, 11=64 bits |
| wide | input | 1 | 1 = 128-bit operation, 0 = low 64 bits only |
| op_a | input | 128 | Minuend (first operand) |
| op_b | input | 128 | Subtrahend (second operand) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 128 | Lane-wise difference, registered |

## Verification
Lane-boundary borrow suppression and narrow-mode pass-through both act on bit 64 in the same cycle. The bench provokes this by subtracting all ones from all zeros with 64-bit lanes and `wide`=0, where the borrow out of bit 63 would otherwise reach the untouched upper half. The same vector is issued at every lane size in both widths, and each result is compared bit for bit with a behavioural model. Issues run back to back while the mode changes on every cycle, and some cycles are idle, so that holding the result and changing the mode are judged against each other on every clock.

// File: rtl/psub_unit.sv
module psub_unit #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   opc,
  input  logic         wide,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int NB = W / 8;
  localparam int HB = NB / 2;

  logic [3:0]   lane_mask;
  logic [NB-2:0] bo;
  logic [W-1:0] diff;

  assign lane_mask = 4'((5'd1 << opc) - 5'd1);

  for (genvar i = 0; i < NB; i++) begin : g_slice
    localparam logic [3:0] IDX = 4'(i);
    logic       cin;
    logic [8:0] s;
    if (i == 0) begin : g_first
      assign cin = 1'b1;
    end else begin : g_link
      assign cin = ((IDX & lane_mask) == 4'd0) ? 1'b1 : bo[i-1];
    end
    assign s = {1'b0, op_a[i*8 +: 8]} + {1'b0, ~op_b[i*8 +: 8]} + {8'd0, cin};
    if (i < NB - 1) begin : g_co
      assign bo[i] = s[8];
    end
    if (i >= HB) begin : g_hi
      assign diff[i*8 +: 8] = wide ? s[7:0] : op_a[i*8 +: 8];
    end else begin : g_lo
      assign diff[i*8 +: 8] = s[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= diff;
    end
  end

  // R6
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(wide)) |->
      result[W-1:W/2] == $past(op_a[W-1:W/2]));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(result));

  // R3
  top_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(wide) && $past(opc) == 2'b00) |->
      result[W-1:W-8] == $past(op_a[W-1:W-8] - op_b[W-1:W-8]));

  // R1
  low_qword_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(opc) == 2'b11) |->
      result[63:0] == $past(op_a[63:0] - op_b[63:0]));
endmodule

// File: tb/test_psub_unit.sv
module test_psub_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   opc = 2'b00;
  logic         wide = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  logic         exp_v = 1'b0;
  logic [127:0] exp_r = '0;

  always #5 clk = ~clk;

  psub_unit i_psub_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opc(opc), .wide(wide),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] c, input logic wd);
    int w = 8 << c;
    int n = (wd ? 128 : 64) / w;
    logic [127:0] r = a;
    for (int l = 0; l < n; l++) begin
      logic [127:0] m = ((128'd1 << w) - 128'd1) << (l * w);
      logic [127:0] d = ((a >> (l * w)) - (b >> (l * w))) << (l * w);
      r = (r & ~m) | (d & m);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic wd,
                      input logic [127:0] a, input logic [127:0] b, input string req);
    @(negedge clk);
    in_valid = v; opc = c; wide = wd; op_a = a; op_b = b;
    exp_v = v;
    if (v) exp_r = model(a, b, c, wd);
    @(posedge clk);
    #1;
    check("R6 valid", {127'd0, out_valid}, {127'd0, exp_v});
    check(req, result, exp_r);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    in_valid = 1'b1;
    op_a = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset valid", {127'd0, out_valid}, 128'd0);
    check("R6 reset result", result, 128'd0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;

    // R3 all zero minus all ones at every lane size and width
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 2'(c), 1'b1, '0, '1, "R3 wide borrow cut");
      step(1'b1, 2'(c), 1'b0, '0, '1, "R3 R5 narrow borrow cut");
    end
    // R2 lane size distinguishable
    for (int c = 0; c < 4; c++)
      step(1'b1, 2'(c), 1'b1, 128'h0100_0000_0001_0000_0100_0000_0001_0000,
           128'h0001_0001_0001_0001_0001_0001_0001_0001, "R2 lane select");
    // R8 signed data
    step(1'b1, 2'b00, 1'b1, {16{8'h80}}, {16{8'h01}}, "R8 signed byte");
    step(1'b1, 2'b01, 1'b1, {8{16'hFFFF}}, {8{16'h0001}}, "R8 signed half");
    step(1'b1, 2'b11, 1'b0, {64'hDEAD_BEEF_0000_0001, 64'h8000_0000_0000_0000},
         {64'h1234, 64'h1}, "R4 R8 narrow quad");
    step(1'b1, 2'b11, 1'b1, {64'h0, 64'h0}, {64'h1, 64'h0}, "R4 two quads");
    // R7 hold when idle
    step(1'b0, 2'b00, 1'b1, '1, 128'h5, "R7 hold");
    step(1'b0, 2'b10, 1'b0, 128'h3, '1, "R7 hold");
    // R1 back to back patterned vectors, changing mode every cycle
    for (int k = 0; k < 40; k++) begin
      logic [127:0] a = {4{32'(k * 32'h9E37_79B9 + 32'h1357)}} ^ {32'(k), 96'h0};
      logic [127:0] b = {4{32'(k * 32'h85EB_CA6B + 32'h2468)}} ^ {96'h0, 32'(k * 7)};
      step((k % 5) != 3, 2'(k), 1'((k / 4) % 2 == 0), a, b, "R1 R4 stream");
    end
    // R6 reset mid stream
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R6 reset mid", {127'd0, out_valid}, 128'd0);
    check("R6 reset mid result", result, 128'd0);
    @(negedge clk);
    rst = 1'b0;
    exp_r = '0;
    step(1'b1, 2'b01, 1'b0, 128'h7, 128'h9, "R1 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule